// File: doc/BRIEF.md
# Change-of-State Interrupt Controller

This block watches a bank of asynchronous digital inputs. It raises one interrupt request when any input changes level, in either direction, while detection is enabled. Each input first passes through a multi-flop synchroniser. The synchronised word is then compared against a registered copy of the previous sample. Any difference between the two counts as a change of state.

The interrupt is a single latched flag, not a per-channel status. Once set, it stays asserted until the host clears it. While it is pending, further input changes are dropped: they are not queued and do not re-trigger the flag later.

The host drives the block through one write-only 16-bit control word. It presents the word on a plain write strobe; there is no readback and no stream handshake. Bit 8 of the word is the enable and bit 0 is a write-one clear. A system with a wider input bank uses one instance for each group of inputs, each instance at its own register offset.

Top module: `cos_irq_ctrl`

## Requirements
- R1: After reset the interrupt output is low and detection is disabled. The control word behaves as if 0x0000 had been written.
- R2: While enabled, a 0-to-1 or 1-to-0 change on any single input sets `irq` high. `irq` is high at the third rising clock edge after the input changes: two synchroniser stages, then the latch.
- R3: A write with bit 8 = 1 enables detection. A write with bit 8 = 0 disables detection and also drops any pending request.
- R4: A write with bit 0 = 1 clears a pending request. A write with bit 0 = 0 and bit 8 = 1 leaves a pending request asserted.
- R5: Bits 15..9 and 7..1 of the control word have no effect, whatever value is written to them.
- R6: Input changes that arrive while a request is pending are discarded. After the clear, `irq` stays low until a new change occurs.
- R7: If a change is detected in the same cycle that a clear write is accepted, the clear wins and that change is lost.
- R8: The previous-sample register keeps tracking the inputs while detection is disabled. Input changes made while disabled therefore do not produce a request once detection is enabled.
- R9: `irq` is an active-high level. Once set, it holds until a clear write or a disable write is accepted.
- R10: Several inputs changing in the same cycle produce exactly one request, identical to a single change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pins_in | input | WIDTH | Asynchronous digital inputs being monitored |
| ctl_wr | input | 1 | One-cycle strobe that writes the control word |
| ctl_wdata | input | 16 | Control word: bit 8 enable, bit 0 clear-on-one |
| irq | output | 1 | Latched change-of-state interrupt request, active high |

## Verification
The bench builds the block with its defaults: a 32-input bank and two synchroniser stages. This makes the three-edge latency of R2 an exact cycle count, and it lets the bench toggle both the lowest and the highest input bit. The bench aligns a clear write with the cycle in which a synchronised change reaches the comparator, which exercises the R7 priority case. It also writes words with every unused bit set, to show that only bits 8 and 0 act.

// File: rtl/cos_irq_pkg.sv
package cos_irq_pkg;
  localparam int CTL_W   = 16;
  localparam int EN_BIT  = 8;
  localparam int CLR_BIT = 0;

  typedef struct packed {
    logic en;
    logic drop;
  } ctl_state_t;
endpackage

// File: rtl/cos_sync_bank.sv
module cos_sync_bank #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= async_in;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign sync_out = stg[STAGES-1];
endmodule

// File: rtl/cos_change_det.sv
module cos_change_det #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] cur,
  output logic             change
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= cur;
  end

  assign change = |(cur ^ prev_q);

  AST_PREV_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> prev_q == $past(cur)); // R8
endmodule

// File: rtl/cos_ctrl_decode.sv
module cos_ctrl_decode
  import cos_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  output ctl_state_t       st
);
  logic en_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      en_q <= 1'b0;
    else if (ctl_wr) en_q <= ctl_wdata[EN_BIT];
  end

  always_comb begin
    st.en   = en_q;
    st.drop = ctl_wr & (ctl_wdata[CLR_BIT] | ~ctl_wdata[EN_BIT]);
  end

  AST_EN_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> en_q == $past(ctl_wdata[EN_BIT])); // R3
  AST_EN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr |=> $stable(en_q)); // R5
endmodule

// File: rtl/cos_irq_latch.sv
module cos_irq_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic change,
  input  logic drop,
  output logic irq_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)             irq_q <= 1'b0;
    else if (drop)          irq_q <= 1'b0;
    else if (en && change)  irq_q <= 1'b1;
  end

  AST_DROP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> !irq_q); // R7
  AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q && !drop |=> irq_q); // R9
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_q && !(en && change) |=> !irq_q); // R6
endmodule

// File: rtl/cos_irq_ctrl.sv
module cos_irq_ctrl
  import cos_irq_pkg::*;
#(
  parameter int WIDTH       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pins_in,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic             irq
);
  logic [WIDTH-1:0] pins_sync;
  logic             change;
  ctl_state_t       st;

  cos_sync_bank #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pins_in), .sync_out(pins_sync)
  );

  cos_change_det #(.WIDTH(WIDTH)) u_det (
    .clk(clk), .rst_n(rst_n), .cur(pins_sync), .change(change)
  );

  cos_ctrl_decode u_ctl (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .st(st)
  );

  cos_irq_latch u_lat (
    .clk(clk), .rst_n(rst_n), .en(st.en), .change(change),
    .drop(st.drop), .irq_q(irq)
  );

  AST_OFF_MEANS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !st.en |-> !irq); // R3
  AST_RISE_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(change && st.en)); // R2
endmodule

// File: tb/sim_cos_irq_ctrl.sv
module sim_cos_irq_ctrl;
  localparam int W = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [W-1:0]  pins_in = '0;
  logic          ctl_wr = 1'b0;
  logic [15:0]   ctl_wdata = '0;
  logic          irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic  exp;
    string req;
  } item_t;
  item_t sb[$];

  always #2.5 clk = ~clk;

  cos_irq_ctrl #(.WIDTH(W), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .pins_in(pins_in),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .irq(irq)
  );

  // monitor: compares queued expectations at the falling edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (irq !== it.exp) begin
        errors++;
        $display("FAIL %s irq actual=%0b expected=%0b", it.req, irq, it.exp);
      end
    end
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic expect_irq(logic v, string req);
    sb.push_back('{exp: v, req: req});
  endtask

  task automatic write_ctl(logic [15:0] v);
    ctl_wr = 1'b1;
    ctl_wdata = v;
    tick();
    ctl_wr = 1'b0;
    ctl_wdata = '0;
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick();
    expect_irq(1'b0, "R1");
    // R1: disabled after reset, changes ignored
    pins_in[3] = 1'b1;
    tick(5);
    expect_irq(1'b0, "R1");

    // R3 enable, R2 rising edge on bit 0 with exact latency
    write_ctl(16'h0100);
    pins_in[0] = 1'b1;
    tick(2);
    expect_irq(1'b0, "R2");
    tick();
    expect_irq(1'b1, "R2");

    // R9 holds; R4 write with clear=0 enable=1 keeps it
    tick(4);
    expect_irq(1'b1, "R9");
    write_ctl(16'h0100);
    expect_irq(1'b1, "R4");
    // R5: all unused bits set, enable kept, no clear
    write_ctl(16'hFFFE);
    tick();
    expect_irq(1'b1, "R5");

    // R6: change while pending discarded
    pins_in[31] = 1'b1;
    tick(5);
    write_ctl(16'h0101);
    expect_irq(1'b0, "R4");
    tick(5);
    expect_irq(1'b0, "R6");

    // R2 falling edge on bit 31
    pins_in[31] = 1'b0;
    tick(3);
    expect_irq(1'b1, "R2");
    write_ctl(16'h0101);
    expect_irq(1'b0, "R4");

    // R7: clear in the cycle the change reaches the comparator
    pins_in[5] = 1'b1;
    tick(3);
    expect_irq(1'b1, "R2");
    pins_in[6] = 1'b1;
    tick(2);
    ctl_wr = 1'b1;
    ctl_wdata = 16'h0101;
    tick();
    ctl_wr = 1'b0;
    ctl_wdata = '0;
    expect_irq(1'b0, "R7");
    tick(4);
    expect_irq(1'b0, "R7");

    // R3: disable drops pending request
    pins_in[7] = 1'b1;
    tick(3);
    expect_irq(1'b1, "R2");
    write_ctl(16'h0000);
    expect_irq(1'b0, "R3");

    // R8: changes while disabled produce nothing after enable
    pins_in[10] = 1'b1;
    pins_in[0]  = 1'b0;
    tick(5);
    write_ctl(16'h0100);
    tick(5);
    expect_irq(1'b0, "R8");

    // R10: many inputs at once give one request, single clear removes it
    pins_in = pins_in ^ 32'hF0F0_00FF;
    tick(3);
    expect_irq(1'b1, "R10");
    write_ctl(16'h0101);
    tick(4);
    expect_irq(1'b0, "R10");

    // R5: unused bits with enable=0 disable; changes then ignored
    write_ctl(16'hFEFE);
    pins_in[20] = ~pins_in[20];
    tick(5);
    expect_irq(1'b0, "R5");

    tick(2);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule